// File: doc/BRIEF.md
# Banked Extended Register Decoder for a 16550-Style UART

This block sits on the 8-bit register port of a 16550-compatible serial controller and opens a second, banked register space behind the standard one. The line-control byte lives here, at offset 3, because it drives the address map. While that byte equals the unlock key 0xBF, offset 2 reaches a feature register. Two bank-select bits in the feature register then pick one of four register groups, which appears at offsets 4 to 7.

Bank 0 holds the software flow-control characters. Bank 1 holds the receive FIFO levels and the transmit threshold. Bank 2 holds an enumeration byte, a read-only hardware identifier and two spare control bytes. Bank 3 is empty.

Every access that does not land on the line-control byte or on the extended space is forwarded to the standard register file through `std_wr` / `std_rd`, and its read data comes back on `std_rdata`. The stored configuration is driven out continuously to the flow-control and receive logic.

Top module: `uart_xreg_decoder`

## Requirements
- R1: After reset `lcr_val` is 0x00 and `feat_cfg` is 0x00. `bank0_cfg` reads 0x00000000, `bank1_cfg` reads {0x00, RX_TRIG_RST, RX_HIGH_RST, RX_LOW_RST} (0x00306008 by default), and `bank2_cfg` reads 0x0000_HW_ID_00. Byte k of each bank word (k = 0..3) is the register at offset 4+k.
- R2: Offset 3 always holds the line-control byte. A write stores `bus_wdata` into `lcr_val` on that clock edge, a read returns it, and `std_wr` / `std_rd` stay low for offset 3.
- R3: While `lcr_val` is not 0xBF (locked), accesses to offsets 0, 1, 2 and 4 to 7 assert `std_wr` / `std_rd` in the same cycle, and reads return `std_rdata`. Such accesses leave `feat_cfg` and all bank words unchanged.
- R4: While `lcr_val` is 0xBF (unlocked), offset 2 reads and writes the feature register and offsets 4 to 7 reach the selected bank. Neither raises `std_wr` / `std_rd`. Offsets 0 and 1 are still forwarded.
- R5: Feature bits 7:6 select the bank (0x00 bank 0, 0x40 bank 1, 0x80 bank 2, 0xC0 bank 3). Feature bit 4 (0x10) drives `enh_en`.
- R6: Bank 0 offsets 4, 5, 6, 7 are XON1, XON2, XOFF1, XOFF2, written and read back in that order.
- R7: Bank 1 offsets 4, 5, 6, 7 are receive low level, receive high level, receive trigger level and transmit threshold.
- R8: Bank 2 offsets 4, 6, 7 are the enumeration, ECR and CSR bytes. Offset 5 always reads the parameter HW_ID, and writes to it are ignored.
- R9: In bank 3, offsets 4 to 7 read 0x00, and writes to them change no bank word.
- R10: Writing any value other than 0xBF to offset 3 relocks the map. Feature and bank contents are kept, and offsets 2 and 4 to 7 return to forwarding.
- R11: Read data is combinational and valid in the cycle `bus_rd` is high. `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| std_rdata | input | 8 | Read data from the standard register file |
| std_wr | output | 1 | Forwarded write strobe for the standard registers |
| std_rd | output | 1 | Forwarded read strobe for the standard registers |
| lcr_val | output | 8 | Stored line-control byte |
| feat_cfg | output | 8 | Stored feature register |
| enh_en | output | 1 | Enhanced-mode enable (feature bit 4) |
| bank0_cfg | output | 32 | Flow-control characters, byte k = offset 4+k |
| bank1_cfg | output | 32 | FIFO levels and threshold, byte k = offset 4+k |
| bank2_cfg | output | 32 | Enumeration, HW_ID, ECR and CSR, byte k = offset 4+k |

## Verification
The hardest case to reach from the ports is the one where nothing should happen: a bank-3 write, a write to the identifier byte, or an offset-4 access after relocking. Each of these must leave every stored byte untouched. The stimulus therefore first fills banks 0 to 2 with distinct, non-default patterns through the unlocked map. It then switches to bank 3 or relocks, issues those writes with all-ones data, and compares all three bank words against the earlier patterns. Read-back after a relock also shows that the forwarded strobes, not the feature register, answer offset 2.

// File: rtl/uart_xreg_pkg.sv
package uart_xreg_pkg;

  typedef enum logic [1:0] {
    TGT_STD  = 2'd0,
    TGT_LCR  = 2'd1,
    TGT_FEAT = 2'd2,
    TGT_BANK = 2'd3
  } tgt_e;

  localparam logic [7:0] UNLOCK_KEY = 8'hBF;
  localparam int         NBANK      = 4;
  localparam int         NSLOT      = 4;
  localparam int         BANKW      = 8 * NSLOT;
  localparam logic [2:0] LCR_OFS    = 3'd3;
  localparam logic [2:0] FEAT_OFS   = 3'd2;

  // Where an access goes, given the offset and whether the key is present.
  function automatic tgt_e route_of(logic [2:0] addr, logic unlocked);
    if (addr == LCR_OFS)                return TGT_LCR;
    if (unlocked && addr == FEAT_OFS)   return TGT_FEAT;
    if (unlocked && addr[2])            return TGT_BANK;
    return TGT_STD;
  endfunction

  function automatic logic [7:0] slot_byte(logic [BANKW-1:0] w, logic [1:0] s);
    return w[int'(s)*8 +: 8];
  endfunction

endpackage

// File: rtl/uart_xreg_route.sv
module uart_xreg_route
  import uart_xreg_pkg::*;
(
  input  logic [2:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [7:0]       lcr,
  input  logic [1:0]       bank_sel,
  output tgt_e             tgt,
  output logic             unlocked,
  output logic             lcr_wr,
  output logic             feat_wr,
  output logic [NBANK-1:0] bank_wr,
  output logic             fwd_wr,
  output logic             fwd_rd
);
  always_comb begin
    unlocked = (lcr == UNLOCK_KEY);
    tgt      = route_of(addr, unlocked);
    lcr_wr   = wr && (tgt == TGT_LCR);
    feat_wr  = wr && (tgt == TGT_FEAT);
    fwd_wr   = wr && (tgt == TGT_STD);
    fwd_rd   = rd && (tgt == TGT_STD);
    bank_wr  = '0;
    if (wr && tgt == TGT_BANK) bank_wr[bank_sel] = 1'b1;
  end
endmodule

// File: rtl/uart_xreg_bank.sv
module uart_xreg_bank
  import uart_xreg_pkg::*;
#(
  parameter logic [BANKW-1:0] RST_VAL = '0,
  parameter logic [NSLOT-1:0] RO_MASK = '0,
  parameter logic [BANKW-1:0] RO_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       slot,
  input  logic [7:0]       wdata,
  output logic [BANKW-1:0] cfg
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (RO_MASK[s]) begin : g_ro
      assign cfg[s*8 +: 8] = RO_VAL[s*8 +: 8];
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= RST_VAL[s*8 +: 8];
        else if (wr_en && slot == 2'(s))     q <= wdata;
      end
      assign cfg[s*8 +: 8] = q;
    end
  end
endmodule

// File: rtl/uart_xreg_decoder.sv
module uart_xreg_decoder
  import uart_xreg_pkg::*;
#(
  parameter logic [7:0] HW_ID       = 8'hA5,
  parameter logic [7:0] RX_LOW_RST  = 8'h08,
  parameter logic [7:0] RX_HIGH_RST = 8'h60,
  parameter logic [7:0] RX_TRIG_RST = 8'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  std_rdata,
  output logic        std_wr,
  output logic        std_rd,
  output logic [7:0]  lcr_val,
  output logic [7:0]  feat_cfg,
  output logic        enh_en,
  output logic [31:0] bank0_cfg,
  output logic [31:0] bank1_cfg,
  output logic [31:0] bank2_cfg
);
  localparam logic [BANKW-1:0] B1_RST = {8'h00, RX_TRIG_RST, RX_HIGH_RST, RX_LOW_RST};
  localparam logic [BANKW-1:0] B2_RO  = {16'h0000, HW_ID, 8'h00};

  tgt_e             tgt;
  logic             unlocked;
  logic             lcr_wr;
  logic             feat_wr;
  logic [NBANK-1:0] bank_wr;
  logic [1:0]       bank_sel;
  logic [1:0]       slot;
  logic [BANKW-1:0] bank_q [NBANK];

  assign bank_sel = feat_cfg[7:6];
  assign slot     = bus_addr[1:0];
  assign enh_en   = feat_cfg[4];

  uart_xreg_route u_route (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .lcr      (lcr_val),
    .bank_sel (bank_sel),
    .tgt      (tgt),
    .unlocked (unlocked),
    .lcr_wr   (lcr_wr),
    .feat_wr  (feat_wr),
    .bank_wr  (bank_wr),
    .fwd_wr   (std_wr),
    .fwd_rd   (std_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_val  <= 8'h00;
      feat_cfg <= 8'h00;
    end else begin
      if (lcr_wr)  lcr_val  <= bus_wdata;
      if (feat_wr) feat_cfg <= bus_wdata;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b < NBANK - 1) begin : g_store
      localparam logic [BANKW-1:0] RST = (b == 1) ? B1_RST : '0;
      localparam logic [NSLOT-1:0] ROM = (b == 2) ? 4'b0010 : 4'b0000;
      uart_xreg_bank #(.RST_VAL(RST), .RO_MASK(ROM), .RO_VAL(B2_RO)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_wr[b]),
        .slot  (slot),
        .wdata (bus_wdata),
        .cfg   (bank_q[b])
      );
    end else begin : g_empty
      assign bank_q[b] = '0;
    end
  end

  assign bank0_cfg = bank_q[0];
  assign bank1_cfg = bank_q[1];
  assign bank2_cfg = bank_q[2];

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      unique case (tgt)
        TGT_LCR:  bus_rdata = lcr_val;
        TGT_FEAT: bus_rdata = feat_cfg;
        TGT_BANK: bus_rdata = slot_byte(bank_q[bank_sel], slot);
        default:  bus_rdata = std_rdata;
      endcase
    end
  end
endmodule

// File: rtl/uart_xreg_decoder_chk.sv
module uart_xreg_decoder_chk #(
  parameter logic [7:0] HW_ID = 8'hA5
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        std_wr,
  input logic        std_rd,
  input logic [7:0]  lcr_val,
  input logic [7:0]  feat_cfg,
  input logic [31:0] bank0_cfg,
  input logic [31:0] bank1_cfg,
  input logic [31:0] bank2_cfg,
  input logic        unlocked,
  input logic [3:0]  bank_wr
);
  assert_lcr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 3'd3 |=> lcr_val == $past(bus_wdata));

  assert_locked_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && bus_wr && bus_addr != 3'd3 |-> std_wr);

  assert_locked_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked && bus_wr && bus_addr[2]
    |=> $stable(bank0_cfg) && $stable(bank1_cfg) && $stable(bank2_cfg));

  assert_unlocked_no_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked && (bus_addr == 3'd2 || bus_addr[2]) |-> !std_wr && !std_rd);

  assert_hwid_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank2_cfg[15:8] == HW_ID);

  assert_bank3_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr[3] |=> $stable(bank0_cfg) && $stable(bank1_cfg) && $stable(bank2_cfg));

  assert_bank3_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked && feat_cfg[7:6] == 2'd3 && bus_rd && bus_addr[2] |-> bus_rdata == 8'h00);

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);
endmodule

bind uart_xreg_decoder uart_xreg_decoder_chk #(.HW_ID(HW_ID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .std_wr    (std_wr),
  .std_rd    (std_rd),
  .lcr_val   (lcr_val),
  .feat_cfg  (feat_cfg),
  .bank0_cfg (bank0_cfg),
  .bank1_cfg (bank1_cfg),
  .bank2_cfg (bank2_cfg),
  .unlocked  (unlocked),
  .bank_wr   (bank_wr)
);

// File: tb/uart_xreg_decoder_tb.sv
module uart_xreg_decoder_tb_top;
  localparam logic [7:0] HWID = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  std_rdata = 8'h5C;
  logic        std_wr, std_rd;
  logic [7:0]  lcr_val, feat_cfg;
  logic        enh_en;
  logic [31:0] bank0_cfg, bank1_cfg, bank2_cfg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  uart_xreg_decoder #(.HW_ID(HWID)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .std_rdata(std_rdata),
    .std_wr(std_wr), .std_rd(std_rd), .lcr_val(lcr_val), .feat_cfg(feat_cfg),
    .enh_en(enh_en), .bank0_cfg(bank0_cfg), .bank1_cfg(bank1_cfg), .bank2_cfg(bank2_cfg)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write: returns the forwarded write strobe seen during the access
  task automatic wr(input logic [2:0] a, input logic [7:0] d, output logic fwd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1 fwd = std_wr;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic fwd);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 begin d = bus_rdata; fwd = std_rd; end
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic f;
    chk("R1 lcr", lcr_val, 8'h00);
    chk("R1 feat", feat_cfg, 8'h00);
    chk("R1 bank0", bank0_cfg, 32'h0);
    chk("R1 bank1", bank1_cfg, 32'h00306008);
    chk("R1 bank2", bank2_cfg, {16'h0, HWID, 8'h0});
    chk("R5 enh_en reset", enh_en, 1'b0);
    #1 chk("R11 idle rdata", bus_rdata, 8'h00);
    rd(3'd3, d, f);
    chk("R2 lcr read", d, 8'h00);
    chk("R2 no std_rd", f, 1'b0);
  endtask

  task automatic t_locked();
    logic [7:0] d; logic f;
    wr(3'd3, 8'h03, f);
    chk("R2 lcr write", lcr_val, 8'h03);
    chk("R2 no std_wr", f, 1'b0);
    wr(3'd2, 8'h11, f);
    chk("R3 fwd wr ofs2", f, 1'b1);
    chk("R3 feat kept", feat_cfg, 8'h00);
    wr(3'd5, 8'h77, f);
    chk("R3 fwd wr ofs5", f, 1'b1);
    chk("R3 bank0 kept", bank0_cfg, 32'h0);
    chk("R3 bank1 kept", bank1_cfg, 32'h00306008);
    rd(3'd6, d, f);
    chk("R3 fwd rd data", d, 8'h5C);
    chk("R3 fwd rd strobe", f, 1'b1);
  endtask

  task automatic t_feature();
    logic [7:0] d; logic f;
    wr(3'd3, 8'hBF, f);
    rd(3'd3, d, f);
    chk("R2 key read", d, 8'hBF);
    wr(3'd2, 8'h10, f);
    chk("R4 feat no fwd", f, 1'b0);
    chk("R5 enh_en", enh_en, 1'b1);
    rd(3'd2, d, f);
    chk("R4 feat read", d, 8'h10);
    chk("R4 feat no std_rd", f, 1'b0);
    wr(3'd0, 8'h42, f);
    chk("R4 ofs0 still fwd", f, 1'b1);
  endtask

  task automatic t_bank0();
    logic [7:0] d; logic f;
    for (int i = 0; i < 4; i++) begin
      wr(3'(4 + i), 8'(8'h11 * (i + 1)), f);
      chk("R4 bank wr no fwd", f, 1'b0);
    end
    chk("R6 bank0 order", bank0_cfg, 32'h44332211);
    rd(3'd6, d, f);
    chk("R6 xoff1 read", d, 8'h33);
  endtask

  task automatic t_bank1();
    logic [7:0] d; logic f;
    wr(3'd2, 8'h50, f);
    chk("R5 feat bank1", feat_cfg, 8'h50);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), 8'(i + 1), f);
    chk("R7 bank1 order", bank1_cfg, 32'h04030201);
    chk("R5 bank0 untouched", bank0_cfg, 32'h44332211);
    rd(3'd5, d, f);
    chk("R7 high read", d, 8'h02);
  endtask

  task automatic t_bank2();
    logic [7:0] d; logic f;
    wr(3'd2, 8'h90, f);
    wr(3'd4, 8'hE1, f);
    wr(3'd5, 8'h99, f);
    wr(3'd6, 8'hE3, f);
    wr(3'd7, 8'hE4, f);
    chk("R8 bank2 word", bank2_cfg, {8'hE4, 8'hE3, HWID, 8'hE1});
    rd(3'd5, d, f);
    chk("R8 hwid read", d, HWID);
    rd(3'd7, d, f);
    chk("R8 csr read", d, 8'hE4);
  endtask

  task automatic t_bank3();
    logic [7:0] d; logic f;
    wr(3'd2, 8'hD0, f);
    for (int i = 4; i < 8; i++) wr(3'(i), 8'hFF, f);
    chk("R9 bank0 kept", bank0_cfg, 32'h44332211);
    chk("R9 bank1 kept", bank1_cfg, 32'h04030201);
    chk("R9 bank2 kept", bank2_cfg, {8'hE4, 8'hE3, HWID, 8'hE1});
    for (int i = 4; i < 8; i++) begin
      rd(3'(i), d, f);
      chk("R9 bank3 read zero", d, 8'h00);
    end
  endtask

  task automatic t_relock();
    logic [7:0] d; logic f;
    std_rdata = 8'hC3;
    wr(3'd3, 8'h1B, f);
    rd(3'd2, d, f);
    chk("R10 ofs2 forwarded", d, 8'hC3);
    chk("R10 feat retained", feat_cfg, 8'hD0);
    wr(3'd4, 8'h00, f);
    chk("R10 ofs4 fwd", f, 1'b1);
    chk("R10 bank0 retained", bank0_cfg, 32'h44332211);
    chk("R10 bank2 retained", bank2_cfg, {8'hE4, 8'hE3, HWID, 8'hE1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_feature();
    t_bank0();
    t_bank1();
    t_bank2();
    t_bank3();
    t_relock();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule